// File: doc/BRIEF.md
# Oscillator with Timed Phase Snapshot

The block is a numerically controlled oscillator. Each clock it adds a tuning word to a 48-bit phase accumulator. Because the accumulator is so wide, the tuning word gives a very fine frequency step. The block drives three outputs from the accumulator:

- the top slice of the phase as a word;
- a square wave taken from the accumulator's most significant bit;
- a 12-bit two's complement sine sample for an external DAC, read from an internal table.

The table is addressed by a 12-bit phase slice.

An asynchronous timing pulse (for example a once-per-second mark from a satellite receiver) passes through a multi-stage synchroniser clocked by the oscillator clock. On the pulse's leading edge, the accumulator is copied into a capture register. The copy is first corrected by the known synchroniser latency: that many tuning-word steps are subtracted. The presented value is therefore the phase in the cycle the pulse arrived, to within the synchroniser's uncertainty of a couple of clock periods.

Captured values leave through a valid/ready output:

- `cap_valid` rises with a new value and stays high, with `cap_phase` held, until a cycle in which `cap_ready` is high.
- A one-cycle `cap_strobe` marks each newly loaded value.
- If a pulse edge arrives while a value is still held and not being accepted, the held value is kept, the new edge is dropped, and `cap_overrun` is raised until the held value is accepted.

Firmware uses the captured phase to steer the tuning word. With a 20 MHz clock, the square output is meant for low comparison frequencies such as 1 or 5 MHz.

Top module: `phase_snap_nco`

## Requirements
- R1: While `rst_n` is low, `phase_out`, `sine_out`, `square_out`, `cap_valid`, `cap_strobe`, `cap_overrun` and `cap_phase` are all zero, and the accumulator and active tuning word are cleared.
- R2: Every clock the accumulator advances, modulo 2^48, by the active tuning word. `phase_out` is accumulator bits [47:32].
- R3: A tuning word presented with `ftw_load` high at clock edge E becomes active at edge E+1. The first accumulator step that uses it is the one at edge E+2; the step at edge E+1 still uses the previous word.
- R4: With the default two synchroniser stages, a pulse that goes high before edge E0 produces `cap_strobe` after edge E0+2. The strobe is not present after edge E0+1, lasts exactly one cycle, and `cap_valid` is high with it.
- R5: `cap_phase` equals the accumulator value as it stood when the pulse went high, when the tuning word is constant over the capture. It is formed as the accumulator minus two tuning-word steps.
- R6: Only a low-to-high transition of the synchronised pulse captures; a pulse held high gives exactly one capture.
- R7: While `cap_valid` is high and `cap_ready` is low, `cap_valid` stays high and `cap_phase` is unchanged. A cycle with both high clears `cap_valid` at the next edge.
- R8: A pulse edge detected while a value is held and `cap_ready` is low leaves `cap_phase` unchanged, gives no strobe, and sets `cap_overrun`. `cap_overrun` clears when the held value is accepted.
- R9: `sine_out` is two's complement and equals round(2047·sin(2π(p+0.5)/4096)) to within 1 LSB. Here p is accumulator bits [47:36] as they stood two edges earlier. The value -2048 never appears.
- R10: `square_out` is accumulator bit 47. With tuning word 2^44 it has a 16-cycle period and is high for 8 cycles of every 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ftw_word | input | 48 | Tuning word to be loaded |
| ftw_load | input | 1 | Load strobe for `ftw_word` |
| evt_in | input | 1 | Asynchronous timing pulse |
| phase_out | output | 16 | Upper accumulator slice |
| sine_out | output | 12 | Sine sample, two's complement |
| square_out | output | 1 | Accumulator most significant bit |
| cap_phase | output | 48 | Latency-corrected captured phase |
| cap_valid | output | 1 | Captured value held and valid |
| cap_ready | input | 1 | Consumer accepts the held value |
| cap_strobe | output | 1 | One-cycle marker of a newly loaded value |
| cap_overrun | output | 1 | A pulse edge was dropped while a value was held |

## Verification
The hardest situation to reach is the overrun. It needs a second, cleanly separated leading edge to make it through the synchroniser while the first capture is still held under back-pressure. The stimulus keeps `cap_ready` low after the first capture and drops the pulse for two cycles so the edge detector re-arms. It then raises the pulse again and confirms that the old phase survives with `cap_overrun` set and no strobe. Random tuning words, with pulses at random offsets, exercise the latency correction across accumulator wrap-around.

// File: rtl/psn_pkg.sv
package psn_pkg;
  localparam int ACC_W_DEF   = 48;
  localparam int OUT_W_DEF   = 16;
  localparam int LUT_AW_DEF  = 12;
  localparam int AMP_W_DEF   = 12;
  localparam int SYNC_N_DEF  = 2;

  // Mirror/negate control derived from the two top phase bits of the table slice
  typedef struct packed {
    logic negate;
    logic mirror;
  } quad_ctl_t;

  function automatic quad_ctl_t quad_decode(input logic [1:0] q);
    quad_ctl_t c;
    c.negate = q[1];
    c.mirror = q[0];
    return c;
  endfunction
endpackage

// File: rtl/psn_tune_buf.sv
module psn_tune_buf #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow;
  logic         pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      pend   <= 1'b0;
      active <= '0;
    end else begin
      pend <= load;
      if (load) shadow <= word;
      if (pend) active <= shadow;
    end
  end

  AST_TUNE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ##1 (active == $past(word, 2))); // R3
endmodule

// File: rtl/psn_accum.sv
module psn_accum #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] step,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + step;
  end
endmodule

// File: rtl/psn_evt_sync.sv
module psn_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sr[g] <= 1'b0;
        else if (g == 0) sr[g] <= evt_async;
        else sr[g] <= sr[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sr[STAGES-1];
  end

  assign rise = sr[STAGES-1] & ~last_q;

  AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/psn_capture.sv
module psn_capture #(
  parameter int W   = 48,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] step,
  input  logic         ready,
  output logic [W-1:0] phase,
  output logic         valid,
  output logic         strobe,
  output logic         overrun
);
  localparam logic [W-1:0] LAT_W = W'(LAT);

  logic [W-1:0] corrected;
  logic         blocked;

  assign corrected = acc - (step * LAT_W);
  assign blocked   = valid & ~ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      valid   <= 1'b0;
      strobe  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (rise && blocked) begin
        overrun <= 1'b1;
      end else if (rise) begin
        phase   <= corrected;
        valid   <= 1'b1;
        strobe  <= 1'b1;
        overrun <= 1'b0;
      end else if (valid && ready) begin
        valid   <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R4
  AST_STROBE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> valid); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(phase))); // R7
  AST_OVR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> valid); // R8
endmodule

// File: rtl/psn_sine.sv
module psn_sine #(
  parameter int PW = 12,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  output logic [AW-1:0] sample
);
  import psn_pkg::*;

  localparam int  QW  = PW - 2;
  localparam int  QN  = 1 << QW;
  localparam int  MW  = AW - 1;
  localparam real AMP = real'((1 << MW) - 1);
  localparam real TAU = 6.283185307179586;
  localparam real FULL = real'(1 << PW);

  logic [MW-1:0] qrom [QN];
  logic [MW-1:0] mag_q;
  logic          neg_q;
  logic [QW-1:0] idx;
  quad_ctl_t     ctl;

  initial begin
    for (int k = 0; k < QN; k++) begin
      qrom[k] = MW'($rtoi(AMP * $sin(TAU * (real'(k) + 0.5) / FULL) + 0.5));
    end
  end

  assign ctl = quad_decode(phase[PW-1:PW-2]);
  assign idx = ctl.mirror ? ~phase[QW-1:0] : phase[QW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_q  <= '0;
      neg_q  <= 1'b0;
      sample <= '0;
    end else begin
      mag_q  <= qrom[idx];
      neg_q  <= ctl.negate;
      sample <= neg_q ? (AW'(0) - {1'b0, mag_q}) : {1'b0, mag_q};
    end
  end

  AST_SINE_SYMM: assert property (@(posedge clk) disable iff (!rst_n)
    sample != {1'b1, {(AW-1){1'b0}}}); // R9
endmodule

// File: rtl/phase_snap_nco.sv
module phase_snap_nco #(
  parameter int ACC_W  = psn_pkg::ACC_W_DEF,
  parameter int OUT_W  = psn_pkg::OUT_W_DEF,
  parameter int LUT_AW = psn_pkg::LUT_AW_DEF,
  parameter int AMP_W  = psn_pkg::AMP_W_DEF,
  parameter int SYNC_N = psn_pkg::SYNC_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] ftw_word,
  input  logic             ftw_load,
  input  logic             evt_in,
  output logic [OUT_W-1:0] phase_out,
  output logic [AMP_W-1:0] sine_out,
  output logic             square_out,
  output logic [ACC_W-1:0] cap_phase,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic             cap_strobe,
  output logic             cap_overrun
);
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc;
  logic             evt_rise;

  psn_tune_buf #(.W(ACC_W)) u_tune (
    .clk(clk), .rst_n(rst_n), .load(ftw_load), .word(ftw_word), .active(step)
  );

  psn_accum #(.W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(step), .acc(acc)
  );

  psn_evt_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_async(evt_in), .rise(evt_rise)
  );

  psn_capture #(.W(ACC_W), .LAT(SYNC_N)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise(evt_rise), .acc(acc), .step(step),
    .ready(cap_ready), .phase(cap_phase), .valid(cap_valid),
    .strobe(cap_strobe), .overrun(cap_overrun)
  );

  psn_sine #(.PW(LUT_AW), .AW(AMP_W)) u_sine (
    .clk(clk), .rst_n(rst_n), .phase(acc[ACC_W-1 -: LUT_AW]), .sample(sine_out)
  );

  assign phase_out  = acc[ACC_W-1 -: OUT_W];
  assign square_out = acc[ACC_W-1];

  AST_STEP_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |=> $stable(phase_out)); // R2
endmodule

// File: tb/phase_snap_nco_tb.sv
module phase_snap_nco_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] ftw_word = '0;
  logic        ftw_load = 1'b0;
  logic        evt_in = 1'b0;
  logic        cap_ready = 1'b0;
  logic [15:0] phase_out;
  logic [11:0] sine_out;
  logic        square_out;
  logic [47:0] cap_phase;
  logic        cap_valid, cap_strobe, cap_overrun;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  phase_snap_nco u_dut (
    .clk(clk), .rst_n(rst_n), .ftw_word(ftw_word), .ftw_load(ftw_load),
    .evt_in(evt_in), .phase_out(phase_out), .sine_out(sine_out),
    .square_out(square_out), .cap_phase(cap_phase), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_strobe(cap_strobe), .cap_overrun(cap_overrun)
  );

  // Requirement-level model: accumulator and tuning-word pipeline (R2, R3)
  logic [47:0] m_acc, m_act, m_shd;
  logic        m_pend;
  logic [11:0] m_h1, m_h2;
  int          m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc <= '0; m_act <= '0; m_shd <= '0; m_pend <= 1'b0;
      m_h1 <= '0; m_h2 <= '0; m_cnt <= 0;
    end else begin
      m_acc  <= m_acc + m_act;
      m_pend <= ftw_load;
      if (ftw_load) m_shd <= ftw_word;
      if (m_pend) m_act <= m_shd;
      m_h1 <= m_acc[47:36];
      m_h2 <= m_h1;
      m_cnt <= m_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_sine(input int p);
    real v;
    v = 2047.0 * $sin(6.283185307179586 * (real'(p) + 0.5) / 4096.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  // Continuous checks of R2, R9, R10 away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished && m_cnt >= 2) begin
      int got, want, d;
      chk(phase_out == m_acc[47:32], "R2 phase_out", 64'(phase_out), 64'(m_acc[47:32]));
      chk(square_out == m_acc[47], "R10 square_out", 64'(square_out), 64'(m_acc[47]));
      got  = int'($signed(sine_out));
      want = exp_sine(int'(m_h2));
      d    = got - want;
      chk((d <= 1) && (d >= -1) && (sine_out != 12'h800), "R9 sine_out",
          64'(sine_out), 64'(12'(want)));
    end
  end

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ftw(input logic [47:0] v);
    ftw_word = v; ftw_load = 1'b1;
    nclk(1);
    ftw_load = 1'b0;
  endtask

  initial begin
    logic [47:0] exp_ph;
    int highs, strobes;
    void'($urandom(32'd20240611));
    nclk(3);
    // R1 reset state
    chk(phase_out == 0 && sine_out == 0 && square_out == 0, "R1 datapath reset",
        {phase_out, sine_out, 3'b0, square_out}, 64'd0);
    chk(!cap_valid && !cap_strobe && !cap_overrun && cap_phase == 0, "R1 capture reset",
        {cap_valid, cap_strobe, cap_overrun}, 64'd0);
    rst_n = 1'b1;
    nclk(2);

    // R3: load at edge E; unchanged after E+1; first step after E+2
    ftw_word = 48'h0100_0000_0000; ftw_load = 1'b1;
    nclk(1); ftw_load = 1'b0;
    chk(phase_out == 16'd0, "R3 no step at E", 64'(phase_out), 64'd0);
    nclk(1);
    chk(phase_out == 16'd0, "R3 old word at E+1", 64'(phase_out), 64'd0);
    nclk(1);
    chk(phase_out == 16'h0100, "R3 new word at E+2", 64'(phase_out), 64'h100);

    // R10: tuning word 2^44 -> 16-cycle period, 8 high
    load_ftw(48'h1000_0000_0000);
    nclk(4);
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      if (square_out) highs++;
      nclk(1);
    end
    chk(highs == 8, "R10 square duty", 64'(highs), 64'd8);

    // R4/R5/R7: directed capture under back-pressure
    load_ftw(48'h1234_5678_9ABC);
    nclk(4);
    cap_ready = 1'b0;
    exp_ph = m_acc;
    evt_in = 1'b1;
    nclk(2);
    chk(!cap_strobe, "R4 no strobe one edge early", 64'(cap_strobe), 64'd0);
    nclk(1);
    chk(cap_strobe && cap_valid, "R4 strobe with valid", {cap_strobe, cap_valid}, 64'd3);
    chk(cap_phase == exp_ph, "R5 corrected phase", 64'(cap_phase), 64'(exp_ph));
    nclk(1);
    chk(!cap_strobe, "R4 strobe one cycle", 64'(cap_strobe), 64'd0);
    chk(cap_valid && cap_phase == exp_ph, "R7 held under back-pressure", 64'(cap_phase), 64'(exp_ph));
    evt_in = 1'b0;
    nclk(3);

    // R8: second edge while held
    evt_in = 1'b1;
    nclk(3);
    chk(cap_overrun && !cap_strobe, "R8 overrun set, no strobe", {cap_overrun, cap_strobe}, 64'd2);
    chk(cap_valid && cap_phase == exp_ph, "R8 old value kept", 64'(cap_phase), 64'(exp_ph));
    evt_in = 1'b0;
    nclk(1);
    cap_ready = 1'b1;
    nclk(1);
    chk(!cap_valid && !cap_overrun, "R7 R8 accept clears", {cap_valid, cap_overrun}, 64'd0);

    // R6: held pulse captures once
    nclk(2);
    evt_in = 1'b1;
    strobes = 0;
    for (int i = 0; i < 14; i++) begin
      nclk(1);
      if (cap_strobe) strobes++;
    end
    chk(strobes == 1, "R6 one capture per leading edge", 64'(strobes), 64'd1);
    evt_in = 1'b0;
    nclk(3);

    // Random tuning words and pulse offsets (R5, R7, R9 via continuous checks)
    for (int it = 0; it < 40; it++) begin
      load_ftw({16'($urandom), 32'($urandom)});
      nclk(4 + int'($urandom % 40));
      exp_ph = m_acc;
      evt_in = 1'b1;
      nclk(3);
      chk(cap_strobe && cap_valid, "R4 random strobe", {cap_strobe, cap_valid}, 64'd3);
      chk(cap_phase == exp_ph, "R5 random capture", 64'(cap_phase), 64'(exp_ph));
      evt_in = 1'b0;
      nclk(1);
      chk(!cap_valid, "R7 ready accepts", 64'(cap_valid), 64'd0);
      nclk(1 + int'($urandom % 8));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule